// File: doc/BRIEF.md
# Selectable Binary Line Encoder

This block turns a serial bit stream into a three-level line symbol. A 2-bit mode input selects the format: on-off, antipodal, alternate-mark-inversion or split-phase. The symbol output is updated at twice the bit rate so that formats with a mid-bit transition can be represented. An external half-bit tick paces the encoder. Two ticks make one bit period. The first tick of each pair opens a new bit.

On the tick that opens a bit, the encoder captures the data bit and the mode and emits the first-half level. On the next tick it emits the second-half level. A one-cycle strobe marks each bit boundary. For the alternate-mark format the encoder keeps the polarity of the last mark sent. That state is cleared by reset, so the first mark after reset goes out positive. Downstream logic maps the signed level onto drivers or a DAC.

Top module: `line_encoder`

## Requirements
- R1: While reset (rst_n low) is held and after its release, before any tick, level_out is 0 (2'b00) and bit_strobe is 0.
- R2: In mode 2'b00 (unipolar), a 1 gives level +1 (2'b01) and a 0 gives level 0 (2'b00).
- R3: In mode 2'b01 (polar), a 1 gives +1 (2'b01) and a 0 gives -1 (2'b11).
- R4: In mode 2'b10 (bipolar), a 0 gives level 0. Each 1 takes the sign opposite to the previous 1 sent in that mode. Bits sent in other modes leave the remembered sign unchanged.
- R5: The first 1 sent in bipolar mode after reset is +1.
- R6: In mode 2'b11 (split-phase), a 1 is +1 for the first half-bit and -1 for the second.
- R7: In mode 2'b11 (split-phase), a 0 is -1 for the first half-bit and +1 for the second.
- R8: In modes 2'b00, 2'b01 and 2'b10, the level of the second half-bit equals the level of the first half-bit.
- R9: The mode is taken only on the tick that opens a bit. A mode change between that tick and the next opening tick has no effect on the current bit.
- R10: The data bit is taken only on the tick that opens a bit. A data change at mid-bit has no effect on the current bit.
- R11: bit_strobe is high for exactly the one cycle after each opening tick. Every new level appears in the cycle after the tick that causes it.
- R12: In a cycle that has no tick, level_out keeps its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| half_tick | input | 1 | One-cycle pulse per half-bit interval |
| data_in | input | 1 | Serial data bit, sampled on the opening tick |
| mode_sel | input | 2 | Line format: 0 unipolar, 1 polar, 2 bipolar, 3 split-phase |
| level_out | output | 2 | Signed line level: 01 = +1, 00 = 0, 11 = -1 |
| bit_strobe | output | 1 | One-cycle pulse at each bit boundary |

## Verification
Every result is due exactly one clock after the tick that produces it. This covers the first-half level with the strobe, and the second-half level without it. The bench drives inputs on the falling edge and compares on the next falling edge, which is the first point where the registered outputs have settled. Between ticks, the bench checks every idle cycle to confirm the level holds (R12). During the same gaps it changes the mode and data inputs to show that they are ignored until the next opening tick (R9, R10). The bipolar sign is predicted by a running sign in the bench, which is reset along with the design.

// File: rtl/line_enc_pkg.sv
package line_enc_pkg;
  localparam int MODE_W = 2;
  localparam int LVL_W  = 2;

  typedef enum logic [MODE_W-1:0] {
    MODE_UNI   = 2'd0,
    MODE_POL   = 2'd1,
    MODE_AMI   = 2'd2,
    MODE_SPLIT = 2'd3
  } lc_mode_e;

  localparam logic [LVL_W-1:0] LVL_POS  = 2'b01;
  localparam logic [LVL_W-1:0] LVL_ZERO = 2'b00;
  localparam logic [LVL_W-1:0] LVL_NEG  = 2'b11;

  // Level for the first half of a bit; last_pos = previous mark was positive
  function automatic logic [LVL_W-1:0] first_half(lc_mode_e m, logic d, logic last_pos);
    logic [LVL_W-1:0] r;
    case (m)
      MODE_UNI:   r = d ? LVL_POS : LVL_ZERO;
      MODE_POL:   r = d ? LVL_POS : LVL_NEG;
      MODE_AMI:   r = d ? (last_pos ? LVL_NEG : LVL_POS) : LVL_ZERO;
      default:    r = d ? LVL_POS : LVL_NEG;
    endcase
    return r;
  endfunction

  // Second half: split-phase inverts the sign, the rest hold
  function automatic logic [LVL_W-1:0] second_half(lc_mode_e m, logic [LVL_W-1:0] first);
    return (m == MODE_SPLIT) ? (~first + 1'b1) : first;
  endfunction
endpackage

// File: rtl/lc_phase_ctl.sv
module lc_phase_ctl (
  input  logic clk,
  input  logic rst_n,
  input  logic half_tick,
  output logic bit_start,
  output logic mid_bit,
  output logic bit_strobe
);
  logic phase;

  assign bit_start = half_tick & ~phase;
  assign mid_bit   = half_tick &  phase;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase      <= 1'b0;
      bit_strobe <= 1'b0;
    end else begin
      if (half_tick) phase <= ~phase;
      bit_strobe <= bit_start;
    end
  end

  p_strobe_after_start_r11: assert property (@(posedge clk) disable iff (!rst_n)
    bit_start |=> bit_strobe);
  p_strobe_single_r11: assert property (@(posedge clk) disable iff (!rst_n)
    bit_strobe |-> !$past(bit_strobe));
endmodule

// File: rtl/lc_mark_polarity.sv
module lc_mark_polarity (
  input  logic clk,
  input  logic rst_n,
  input  logic mark_evt,
  output logic last_pos
);
  always_ff @(posedge clk) begin
    if (!rst_n)        last_pos <= 1'b0;
    else if (mark_evt) last_pos <= ~last_pos;
  end

  p_mark_flips_r4: assert property (@(posedge clk) disable iff (!rst_n)
    mark_evt |=> (last_pos != $past(last_pos)));
  p_no_mark_holds_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !mark_evt |=> $stable(last_pos));
endmodule

// File: rtl/line_encoder.sv
module line_encoder
  import line_enc_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              half_tick,
  input  logic              data_in,
  input  logic [MODE_W-1:0] mode_sel,
  output logic [LVL_W-1:0]  level_out,
  output logic              bit_strobe
);
  logic     bit_start, mid_bit, last_pos, mark_evt;
  lc_mode_e mode_now, mode_q;

  assign mode_now = lc_mode_e'(mode_sel);
  assign mark_evt = bit_start && (mode_now == MODE_AMI) && data_in;

  lc_phase_ctl u_phase (
    .clk(clk), .rst_n(rst_n), .half_tick(half_tick),
    .bit_start(bit_start), .mid_bit(mid_bit), .bit_strobe(bit_strobe)
  );

  lc_mark_polarity u_pol (
    .clk(clk), .rst_n(rst_n), .mark_evt(mark_evt), .last_pos(last_pos)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode_q    <= MODE_UNI;
      level_out <= LVL_ZERO;
    end else if (bit_start) begin
      mode_q    <= mode_now;
      level_out <= first_half(mode_now, data_in, last_pos);
    end else if (mid_bit) begin
      level_out <= second_half(mode_q, level_out);
    end
  end

  p_level_legal_r2: assert property (@(posedge clk) disable iff (!rst_n)
    level_out != 2'b10);
  p_hold_no_tick_r12: assert property (@(posedge clk) disable iff (!rst_n)
    !half_tick |=> $stable(level_out));
  p_nrz_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (mid_bit && mode_q != MODE_SPLIT) |=> $stable(level_out));
  p_split_flip_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (mid_bit && mode_q == MODE_SPLIT) |=> (level_out != $past(level_out) && level_out != LVL_ZERO));
  p_ami_space_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (bit_start && mode_now == MODE_AMI && !data_in) |=> level_out == LVL_ZERO);
endmodule

// File: tb/line_encoder_tb.sv
module line_encoder_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       half_tick = 1'b0;
  logic       data_in = 1'b0;
  logic [1:0] mode_sel = 2'd0;
  logic [1:0] level_out;
  logic       bit_strobe;

  int n_vec = 0;
  int n_miss = 0;
  int next_sign = 1;
  bit done = 1'b0;

  always #10 clk = ~clk;

  line_encoder u_dut (
    .clk(clk), .rst_n(rst_n), .half_tick(half_tick), .data_in(data_in),
    .mode_sel(mode_sel), .level_out(level_out), .bit_strobe(bit_strobe)
  );

  function automatic int lvl();
    return int'($signed(level_out));
  endfunction

  // Expected first-half level; updates the bipolar sign model
  function automatic int exp_first(int m, bit d);
    int r;
    if (m == 2) begin
      r = d ? next_sign : 0;
      if (d) next_sign = -next_sign;
    end else if (m == 0) r = d ? 1 : 0;
    else r = d ? 1 : -1;
    return r;
  endfunction

  function automatic int exp_second(int m, int first);
    return (m == 3) ? -first : first;
  endfunction

  task automatic chk(string req, int act, int exp);
    n_vec++;
    if (act != exp) begin
      n_miss++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic string mode_req(int m, bit d, bit second);
    if (m == 3) return d ? "R6" : "R7";
    if (second) return "R8";
    if (m == 0) return "R2";
    if (m == 1) return "R3";
    return "R4";
  endfunction

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; half_tick = 1'b0;
    repeat (2) @(negedge clk);
    chk("R1 level in reset", lvl(), 0);
    chk("R1 strobe in reset", int'(bit_strobe), 0);
    rst_n = 1'b1;
    next_sign = 1;
    @(negedge clk);
    chk("R1 level after release", lvl(), 0);
    chk("R1 strobe after release", int'(bit_strobe), 0);
  endtask

  task automatic send_bit(bit d, int m, int gap1, int gap2, bit disturb);
    int e1, e2;
    half_tick = 1'b1; data_in = d; mode_sel = 2'(m);
    e1 = exp_first(m, d);
    e2 = exp_second(m, e1);
    @(negedge clk);
    half_tick = 1'b0;
    chk("R11 strobe at bit start", int'(bit_strobe), 1);
    chk(mode_req(m, d, 1'b0), lvl(), e1);
    if (disturb) begin
      data_in  = ~d;                      // R10 mid-bit data change
      mode_sel = 2'(m) ^ 2'($urandom_range(1, 3)); // R9 mid-bit mode change
    end
    for (int i = 0; i < gap1; i++) begin
      @(negedge clk);
      chk("R12 hold first half", lvl(), e1);
      chk("R11 strobe single", int'(bit_strobe), 0);
    end
    half_tick = 1'b1;
    @(negedge clk);
    half_tick = 1'b0;
    chk(disturb ? "R9 R10 second half" : mode_req(m, d, 1'b1), lvl(), e2);
    chk("R11 no strobe mid-bit", int'(bit_strobe), 0);
    for (int i = 0; i < gap2; i++) begin
      @(negedge clk);
      chk("R12 hold second half", lvl(), e2);
    end
  endtask

  initial begin
    void'($urandom(32'd2024));
    do_reset();
    // Directed: each format with both bit values
    for (int m = 0; m < 4; m++) begin
      send_bit(1'b1, m, 0, 0, 1'b0);
      send_bit(1'b0, m, 1, 1, 1'b0);
    end
    // R5: first mark after reset is positive, then alternation (R4)
    do_reset();
    send_bit(1'b1, 2, 0, 0, 1'b0);
    send_bit(1'b0, 2, 0, 0, 1'b0);
    send_bit(1'b1, 2, 0, 0, 1'b0);
    send_bit(1'b1, 2, 2, 0, 1'b0);
    // Other modes leave bipolar sign untouched (R4)
    send_bit(1'b1, 1, 0, 0, 1'b0);
    send_bit(1'b1, 2, 0, 0, 1'b0);
    // Mid-bit disturbances (R9, R10)
    for (int m = 0; m < 4; m++) send_bit(1'b1, m, 2, 0, 1'b1);
    // Random mix
    for (int k = 0; k < 400; k++)
      send_bit(1'($urandom_range(0, 1)), $urandom_range(0, 3),
               $urandom_range(0, 3), $urandom_range(0, 3), 1'($urandom_range(0, 1)));
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_miss);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_miss++;
      $display("FAIL watchdog: run did not complete");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_miss);
      $finish;
    end
  end
endmodule